// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block is the address front end of a synchronous pipelined burst SRAM. When an address strobe is sampled while the device is selected and ready, it captures a word address. It then walks the two lowest address bits through a four-beat burst. The order is either interleaved, where each beat is the start value XOR the beat number, or linear, where each beat is the start value plus the beat number modulo four. The order is picked by a mode input, which is sampled together with the address. The upper address bits stay at the captured value for the whole burst.

A power controller runs beside the sequencer. An asynchronous sleep request passes through a two-flop synchronizer into a four-state machine (active, entering, asleep, exiting). Entry and exit each take two cycles. Any burst still open when entry begins is discarded. After exit, a recovery window of `REC_CYC` cycles follows. Address strobes are refused whenever the block is not ready. While refused, a strobe raises an error flag.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_out` is 0, `ready` is 1, `asleep` is 0 and `strobe_err` is 0 while no strobe is asserted.
- R2: A rising edge with either strobe (`ads_a_n` or `ads_b_n`) low, every bit of `sel_n` low and `ready` high loads `addr_in`, and `addr_out` equals it right after that edge.
- R3: With `order_sel` = 1 at load, beat n (n = 0..3) shows low bits equal to start XOR n.
- R4: With `order_sel` = 0 at load, beat n shows low bits equal to (start + n) mod 4.
- R5: Each edge with `adv_n` low moves to the next beat. The fifth beat returns to the start value. An edge with `adv_n` high holds `addr_out`.
- R6: Bits above bit 1 of `addr_out` keep their loaded value for the whole burst.
- R7: A strobe while any bit of `sel_n` is high leaves `addr_out` unchanged.
- R8: A strobe during a burst reloads the address and restarts at beat 0. A load takes priority over advance in the same edge.
- R9: After `sleep_req` rises, `ready` stays high through the 2nd rising edge and is low after the 3rd. `asleep` is high after the 5th.
- R10: After `sleep_req` falls, `asleep` is low after the 3rd rising edge. `ready` stays low until the (5+REC_CYC)th edge and is high after it.
- R11: While `ready` is low, a strobe does not load, and `strobe_err` is high in the same cycle.
- R12: A burst open when sleep entry starts is discarded: after wake-up, `adv_n` low leaves `addr_out` unchanged until a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | AW | Word address to capture |
| sel_n | input | NCE | Chip enables, all must be low to select |
| ads_a_n | input | 1 | Address strobe A, active low |
| ads_b_n | input | 1 | Address strobe B, active low |
| adv_n | input | 1 | Advance to next beat, active low |
| order_sel | input | 1 | 1 interleaved, 0 linear (tie high by default) |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| addr_out | output | AW | Current internal word address |
| ready | output | 1 | Active and past recovery; strobes accepted |
| asleep | output | 1 | Sleep state reached |
| strobe_err | output | 1 | Strobe seen while not ready |

## Verification
A wrong beat counter or order flag shows up on the low two bits of `addr_out` one edge after the advance that reaches it. The bench sweeps every start value in both orders across the wrap, so such a fault is visible within five beats. A wrong power state moves the edges at which `ready` or `asleep` change by at least one cycle, and the bench samples each of those edges. A burst that survives sleep shows up as an address change on the first advance after wake-up.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_ENTER  = 2'd1,
    PS_SLEEP  = 2'd2,
    PS_EXIT   = 2'd3
  } pwr_state_t;

  // Low two bits for a given beat; interleave picks XOR order, else mod-4 add.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       interleave);
    logic [1:0] r;
    if (interleave) r = start ^ beat;
    else            r = start + beat;
    return r;
  endfunction

endpackage

// File: rtl/bseq_sync.sv
module bseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bseq_pwr.sv
module bseq_pwr
  import burst_seq_pkg::*;
#(
  parameter int ENTER_CYC = 2,
  parameter int EXIT_CYC  = 2,
  parameter int REC_CYC   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic active,
  output logic ready,
  output logic asleep
);
  localparam int PMAX = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
  localparam int PW   = $clog2(PMAX + 1);
  localparam int RW   = $clog2(REC_CYC + 2);

  pwr_state_t    state;
  logic [PW-1:0] phase;
  logic [RW-1:0] rec_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= PS_ACTIVE;
      phase   <= '0;
      rec_cnt <= '0;
    end else begin
      case (state)
        PS_ACTIVE: begin
          if (rec_cnt != '0) rec_cnt <= rec_cnt - 1'b1;
          if (req) begin
            state   <= PS_ENTER;
            phase   <= '0;
            rec_cnt <= '0;
          end
        end
        PS_ENTER: begin
          if (phase == PW'(ENTER_CYC - 1)) state <= PS_SLEEP;
          else                             phase <= phase + 1'b1;
        end
        PS_SLEEP: begin
          if (!req) begin
            state <= PS_EXIT;
            phase <= '0;
          end
        end
        default: begin
          if (phase == PW'(EXIT_CYC - 1)) begin
            state   <= PS_ACTIVE;
            rec_cnt <= RW'(REC_CYC);
          end else begin
            phase <= phase + 1'b1;
          end
        end
      endcase
    end
  end

  assign active = (state == PS_ACTIVE);
  assign ready  = active && (rec_cnt == '0);
  assign asleep = (state == PS_SLEEP);

  a_r9_sleep_via_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_SLEEP && $past(state) != PS_SLEEP) |-> $past(state) == PS_ENTER);
  a_r10_active_via_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_ACTIVE && $past(state) != PS_ACTIVE) |-> $past(state) == PS_EXIT);
  a_r10_rec_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_EXIT && phase == PW'(EXIT_CYC - 1)) |=> !ready);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(asleep && ready));
endmodule

// File: rtl/bseq_burst.sv
module bseq_burst
  import burst_seq_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          kill,
  input  logic [AW-1:0] start_addr,
  input  logic          interleave,
  output logic [AW-1:0] addr_out
);
  logic [AW-1:0] base;
  logic [1:0]    beat;
  logic          burst_on;
  logic          ilv;
  logic          adv_take;

  assign adv_take = step && burst_on && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base     <= '0;
      beat     <= '0;
      burst_on <= 1'b0;
      ilv      <= 1'b1;
    end else if (kill) begin
      burst_on <= 1'b0;
    end else if (load) begin
      base     <= start_addr;
      beat     <= '0;
      burst_on <= 1'b1;
      ilv      <= interleave;
    end else if (adv_take) begin
      beat <= beat + 1'b1;
    end
  end

  assign addr_out = {base[AW-1:2], beat_low(base[1:0], beat, ilv)};

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_take) |=> $stable(addr_out));
  a_r6_upper: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(addr_out[AW-1:2]));
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !kill) |=> addr_out == $past(start_addr));
  a_r4_lin_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_take && !kill && !ilv) |=> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1);
  a_r12_kill: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !burst_on);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int AW        = 20,
  parameter int NCE       = 3,
  parameter int ENTER_CYC = 2,
  parameter int EXIT_CYC  = 2,
  parameter int REC_CYC   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr_in,
  input  logic [NCE-1:0] sel_n,
  input  logic           ads_a_n,
  input  logic           ads_b_n,
  input  logic           adv_n,
  input  logic           order_sel,
  input  logic           sleep_req,
  output logic [AW-1:0]  addr_out,
  output logic           ready,
  output logic           asleep,
  output logic           strobe_err
);
  logic req_s;
  logic pwr_active;
  logic sel_ok;
  logic strobe_any;
  logic load_ev;
  logic step_ev;
  logic kill_ev;

  bseq_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sleep_req), .q(req_s)
  );

  bseq_pwr #(.ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC), .REC_CYC(REC_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .req(req_s),
    .active(pwr_active), .ready(ready), .asleep(asleep)
  );

  assign sel_ok     = ~|sel_n;
  assign strobe_any = ~ads_a_n | ~ads_b_n;
  assign load_ev    = strobe_any & sel_ok & ready;
  assign step_ev    = ~adv_n & ready;
  assign kill_ev    = ~pwr_active;
  assign strobe_err = strobe_any & ~ready;

  bseq_burst #(.AW(AW)) u_burst (
    .clk(clk), .rst_n(rst_n), .load(load_ev), .step(step_ev), .kill(kill_ev),
    .start_addr(addr_in), .interleave(order_sel), .addr_out(addr_out)
  );

  a_r11_no_load_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_err |=> $stable(addr_out));
  a_r7_desel_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ok && (adv_n || !ready)) |=> $stable(addr_out));
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 20;
  localparam int NCE = 3;
  localparam int REC = 2;
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [NCE-1:0] sel_n = '1;
  logic ads_a_n = 1'b1, ads_b_n = 1'b1, adv_n = 1'b1, order_sel = 1'b1, sleep_req = 1'b0;
  logic [AW-1:0] addr_out;
  logic ready, asleep, strobe_err;
  int total = 0, bad = 0;
  bit done = 0;

  burst_addr_seq #(.AW(AW), .NCE(NCE), .REC_CYC(REC)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .sel_n(sel_n),
    .ads_a_n(ads_a_n), .ads_b_n(ads_b_n), .adv_n(adv_n), .order_sel(order_sel),
    .sleep_req(sleep_req), .addr_out(addr_out), .ready(ready), .asleep(asleep),
    .strobe_err(strobe_err)
  );

  always #(TCLK/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [1:0] want_low(input int s, input int n, input bit ilv);
    if (ilv) return 2'(s ^ n);
    return 2'((s + n) % 4);
  endfunction

  task automatic do_load(input logic [AW-1:0] a, input bit ilv, input bit use_b);
    addr_in = a; order_sel = ilv; sel_n = '0;
    if (use_b) ads_b_n = 1'b0; else ads_a_n = 1'b0;
    tick();
    ads_a_n = 1'b1; ads_b_n = 1'b1;
  endtask

  task automatic adv1();
    adv_n = 1'b0; tick(); adv_n = 1'b1;
  endtask

  initial begin
    #(TCLK * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] a, held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R1 addr", addr_out, 0);
    chk("R1 ready", ready, 1);
    chk("R1 asleep", asleep, 0);
    chk("R1 err", strobe_err, 0);

    // R3/R4/R5/R6 sweep: every start, both orders, through the wrap
    for (int ilv = 0; ilv < 2; ilv++) begin
      for (int s = 0; s < 4; s++) begin
        a = AW'((32'h5A3C4 * (s + 1) + ilv * 32'h1234) << 2) | AW'(s);
        do_load(a, ilv[0], s[0]);
        chk("R2 load", addr_out, a);
        for (int n = 1; n <= 4; n++) begin
          adv1();
          chk(ilv ? "R3 interleaved beat" : "R4 linear beat", addr_out[1:0], want_low(s, n % 4, ilv[0]));
          chk("R6 upper held", addr_out[AW-1:2], a[AW-1:2]);
        end
        chk("R5 wrap to start", addr_out, a);
        held = addr_out;
        tick();
        chk("R5 hold adv high", addr_out, held);
      end
    end

    // R7: deselected strobe ignored
    do_load(20'h00011, 1'b1, 1'b0);
    held = addr_out;
    for (int b = 0; b < NCE; b++) begin
      addr_in = 20'hFFFFF; sel_n = '0; sel_n[b] = 1'b1; ads_a_n = 1'b0;
      tick();
      ads_a_n = 1'b1;
      chk("R7 deselected strobe", addr_out, held);
    end

    // R8: restart mid-burst, load beats advance in same edge
    do_load(20'h00402, 1'b0, 1'b0);
    adv1();
    addr_in = 20'h00803; order_sel = 1'b0; sel_n = '0; ads_b_n = 1'b0; adv_n = 1'b0;
    tick();
    ads_b_n = 1'b1; adv_n = 1'b1;
    chk("R8 reload priority", addr_out, 20'h00803);
    adv1();
    chk("R8 restart beat1", addr_out, 20'h00800);

    // R9 entry timing with a burst open (R12)
    do_load(20'h00C01, 1'b1, 1'b0);
    adv1();
    held = addr_out;
    sel_n = '1;
    sleep_req = 1'b1;
    for (int e = 1; e <= 5; e++) begin
      tick();
      chk("R9 ready", ready, (e <= 2) ? 1 : 0);
      chk("R9 asleep", asleep, (e >= 5) ? 1 : 0);
    end
    // R11 in sleep: strobe flagged and not loaded
    addr_in = 20'h0F0F0; sel_n = '0; ads_a_n = 1'b0;
    #1;
    chk("R11 err in sleep", strobe_err, 1);
    tick();
    ads_a_n = 1'b1; sel_n = '1;
    chk("R11 no load in sleep", addr_out, held);

    // R10 exit timing and recovery lockout
    sleep_req = 1'b0;
    for (int e = 1; e <= 5 + REC; e++) begin
      if (e > 5) begin
        addr_in = 20'h0ABCD; sel_n = '0; ads_a_n = 1'b0;
        #1;
        chk("R11 err in recovery", strobe_err, 1);
      end
      tick();
      ads_a_n = 1'b1; sel_n = '1;
      chk("R10 asleep", asleep, (e >= 3) ? 0 : 1);
      chk("R10 ready", ready, (e >= 5 + REC) ? 1 : 0);
    end
    chk("R11 no load in recovery", addr_out, held);
    chk("R11 err cleared", strobe_err, 0);

    // R12: burst discarded by sleep
    adv1();
    chk("R12 adv ignored after wake", addr_out, held);
    adv1();
    chk("R12 adv ignored again", addr_out, held);
    do_load(20'h01002, 1'b1, 1'b1);
    adv1();
    chk("R12 new burst advances", addr_out, 20'h01003);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule